// File: doc/BRIEF.md
# Runtime-Programmable Divide-by-N Clock Generator with Balanced Duty

This block takes a free-running input clock and produces a slower clock whose period is N input cycles, with N chosen at runtime from the divisor pin. The divided clock is high for exactly half of its period whether N is even or odd. When N is odd, the high time ends in the middle of an input cycle. That half-cycle is built by retiming the rising-edge phase register onto the falling edge of the input clock and combining the two. A second output, the tick, is a one-cycle strobe at the divided rate. It is meant as a clock enable for logic that stays on the input clock.

A divisor value is taken only at the boundary between two output periods, so a running period is never cut short or stretched. Values outside 2 to 16 are clamped into that range. The duty balance for odd N is only as good as the duty of the input clock, because the falling edge sets the width of the extra half cycle. All pins are plain control pins and carry no data stream, so there is no handshake.

Top module: `duty_clk_div`

## Requirements
- R1: For a divisor value N in 2..16 (unsigned, 5-bit pin), consecutive rising edges of `tick_o` are exactly N input cycles apart.
- R2: `tick_o` is high for exactly one input cycle per output period and is never high in two consecutive cycles.
- R3: Over each output period of 2N input half-cycles, `clk_div_o` is high for exactly N half-cycles, for both even and odd N.
- R4: A divisor value of 0 or 1 acts as 2, and any value from 17 to 31 acts as 16.
- R5: The divisor pin is sampled only at the input rising edge that starts a new output period. A change at any other time, including the last cycle of a period, leaves the running period at its old length and applies from the next period on.
- R6: While `rst_i` is high at a rising edge, both outputs are low from that edge on. The first `tick_o` after the last reset edge comes exactly N input rising edges later, so the first period is a full one.
- R7: `tick_o` and the output period start together. For even N, `clk_div_o` rises at the same input rising edge as `tick_o`. For odd N, it rises at the following input falling edge, half a cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; both edges are used |
| rst_i | input | 1 | Active-high synchronous reset |
| div_i | input | 5 | Requested divisor N, unsigned, clamped to 2..16 |
| clk_div_o | output | 1 | Divided clock with balanced duty |
| tick_o | output | 1 | One-cycle strobe, once per output period |

## Verification
The hardest case to reach from the ports is a divisor change that lands in the last input cycle before a period boundary. A fault in the sampling point shows up only in that one cycle. The same holds for a switch between odd and even N, where the falling-edge register has to hand over cleanly. The stimulus places each divisor change at a random offset inside the running period, and the last cycle is one of the offsets it can pick. Directed cases force odd-to-even and even-to-odd changes at that last cycle. Every period is measured by sampling the divided clock once per half cycle, so each change is checked against the length and duty expected for the period before it and the period after it.

// File: rtl/duty_div_pkg.sv
package duty_div_pkg;
  // Default widths and divisor limits shared by the divider and its checker.
  localparam int unsigned DDIV_SEL_W = 5;
  localparam int unsigned DDIV_N_MIN = 2;
  localparam int unsigned DDIV_N_MAX = 16;
endpackage

// File: rtl/ddiv_sel_clamp.sv
// Maps a raw divisor value onto the supported range.
module ddiv_sel_clamp #(
  parameter int unsigned SEL_W = duty_div_pkg::DDIV_SEL_W,
  parameter int unsigned N_MIN = duty_div_pkg::DDIV_N_MIN,
  parameter int unsigned N_MAX = duty_div_pkg::DDIV_N_MAX
) (
  input  logic [SEL_W-1:0] raw_i,
  output logic [SEL_W-1:0] sel_o
);
  localparam logic [SEL_W-1:0] LO = SEL_W'(N_MIN);
  localparam logic [SEL_W-1:0] HI = SEL_W'(N_MAX);

  always_comb begin
    if (raw_i < LO)      sel_o = LO;
    else if (raw_i > HI) sel_o = HI;
    else                 sel_o = raw_i;
  end
endmodule

// File: rtl/ddiv_period_ctr.sv
// Counts input cycles within an output period, latches the divisor at each
// period boundary and registers the tick strobe.
module ddiv_period_ctr #(
  parameter int unsigned SEL_W = duty_div_pkg::DDIV_SEL_W,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SEL_W-1:0] nsel_o,
  output logic             wrap_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] nsel_q;
  logic             tick_q;

  // Last cycle of the running period.
  assign wrap_o = (SEL_W'(cnt_q) == (nsel_q - SEL_W'(1)));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      nsel_q <= sel_i;
      tick_q <= 1'b0;
    end else if (wrap_o) begin
      cnt_q  <= '0;
      nsel_q <= sel_i;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign nsel_o = nsel_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/ddiv_phase_gen.sv
// Builds the divided clock from a rising-edge phase register and a copy of
// it retimed to the falling edge. Odd divisors AND the two copies; even
// divisors pass the rising-edge phase straight through.
module ddiv_phase_gen #(
  parameter int unsigned SEL_W = duty_div_pkg::DDIV_SEL_W,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SEL_W-1:0] nsel_i,
  input  logic             wrap_i,
  output logic             clk_div_o
);
  logic             rise_ph_q;
  logic             fall_ph_q;
  logic [SEL_W-1:0] hi_cycles;
  logic             ph_end;

  // The rising-edge phase stays high for ceil(N/2) cycles.
  assign hi_cycles = (nsel_i + SEL_W'(1)) >> 1;
  assign ph_end    = ((SEL_W'(cnt_i) + SEL_W'(1)) == hi_cycles);

  always_ff @(posedge clk_i) begin
    if (rst_i)       rise_ph_q <= 1'b0;
    else if (wrap_i) rise_ph_q <= 1'b1;
    else if (ph_end) rise_ph_q <= 1'b0;
  end

  always_ff @(negedge clk_i) begin
    if (rst_i) fall_ph_q <= 1'b0;
    else       fall_ph_q <= rise_ph_q;
  end

  // The divisor register changes only when rise_ph_q rises, and fall_ph_q
  // is low at that point, so the select never cuts a high phase.
  assign clk_div_o = rise_ph_q & (fall_ph_q | ~nsel_i[0]);
endmodule

// File: rtl/duty_clk_div.sv
module duty_clk_div #(
  parameter int unsigned SEL_W = duty_div_pkg::DDIV_SEL_W,
  parameter int unsigned N_MIN = duty_div_pkg::DDIV_N_MIN,
  parameter int unsigned N_MAX = duty_div_pkg::DDIV_N_MAX
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] div_i,
  output logic             clk_div_o,
  output logic             tick_o
);
  localparam int unsigned CNT_W = $clog2(N_MAX);

  logic [SEL_W-1:0] sel_clamped;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] nsel_q;
  logic             wrap;

  ddiv_sel_clamp #(.SEL_W(SEL_W), .N_MIN(N_MIN), .N_MAX(N_MAX)) u_clamp (
    .raw_i (div_i),
    .sel_o (sel_clamped)
  );

  ddiv_period_ctr #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .sel_i  (sel_clamped),
    .cnt_o  (cnt_q),
    .nsel_o (nsel_q),
    .wrap_o (wrap),
    .tick_o (tick_o)
  );

  ddiv_phase_gen #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_phase (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cnt_i     (cnt_q),
    .nsel_i    (nsel_q),
    .wrap_i    (wrap),
    .clk_div_o (clk_div_o)
  );
endmodule

// File: rtl/ddiv_checker.sv
module ddiv_checker #(
  parameter int unsigned SEL_W = duty_div_pkg::DDIV_SEL_W,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned N_MIN = duty_div_pkg::DDIV_N_MIN,
  parameter int unsigned N_MAX = duty_div_pkg::DDIV_N_MAX
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             tick_o,
  input logic             clk_div_o,
  input logic [CNT_W-1:0] cnt,
  input logic [SEL_W-1:0] nsel,
  input logic             wrap
);
  // R2: the tick never lasts two cycles.
  a_r2_tick_single: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o);

  // R7: by the end of the tick cycle the divided clock is high.
  a_r7_tick_aligned: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |-> clk_div_o);

  // R6: a reset edge silences both outputs.
  a_r6_reset_quiet: assert property (@(posedge clk_i)
    rst_i |=> (!tick_o && !clk_div_o));

  // R4: the active divisor stays in range.
  a_r4_sel_range: assert property (@(posedge clk_i) disable iff (rst_i)
    (nsel >= SEL_W'(N_MIN)) && (nsel <= SEL_W'(N_MAX)));

  // R5: the active divisor changes only at a period boundary.
  a_r5_sel_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap |=> $stable(nsel));

  // R1: the cycle counter stays below the active divisor.
  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    SEL_W'(cnt) < nsel);
endmodule

bind duty_clk_div ddiv_checker #(
  .SEL_W(SEL_W), .CNT_W(CNT_W), .N_MIN(N_MIN), .N_MAX(N_MAX)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .tick_o    (tick_o),
  .clk_div_o (clk_div_o),
  .cnt       (cnt_q),
  .nsel      (nsel_q),
  .wrap      (wrap)
);

// File: tb/duty_clk_div_tb.sv
module duty_clk_div_tb;
  logic       clk = 1'b0;
  logic       rst_i = 1'b1;
  logic [4:0] div_i = 5'd2;
  logic       clk_div_o;
  logic       tick_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5ns clk = ~clk;  // 200 MHz

  duty_clk_div u_dut (
    .clk_i     (clk),
    .rst_i     (rst_i),
    .div_i     (div_i),
    .clk_div_o (clk_div_o),
    .tick_o    (tick_o)
  );

  function automatic int ref_clamp(input int r);
    if (r < 2)  return 2;
    if (r > 16) return 16;
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Holds reset, checks the quiet outputs, releases and returns the number
  // of rising edges up to the first tick (sampled 1 ns after each edge).
  task automatic do_reset(input logic [4:0] d, output int lat);
    @(posedge clk); #1ns;
    rst_i = 1'b1;
    div_i = d;
    repeat (3) begin @(posedge clk); #1ns; end
    chk("R6 tick low in reset", int'(tick_o), 0);
    chk("R6 clk_div low in reset", int'(clk_div_o), 0);
    rst_i = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); #1ns;
      lat++;
    end while (!tick_o && lat < 40);
  endtask

  // Starts 1 ns after the edge that raised tick_o. Returns the cycles to the
  // next tick, the number of high half-cycle samples and the first sample.
  task automatic run_period(input int change_at, input logic [4:0] nd,
                            output int cyc, output int hi, output int first);
    cyc = 0;
    hi = 0;
    first = int'(clk_div_o);
    forever begin
      hi += int'(clk_div_o);
      @(negedge clk); #1ns;
      hi += int'(clk_div_o);
      @(posedge clk); #1ns;
      cyc++;
      if (change_at != 0 && cyc == change_at) div_i = nd;
      if (tick_o || cyc >= 40) break;
    end
  endtask

  task automatic check_period(input int n_exp, input int change_at,
                              input logic [4:0] nd, input string tag);
    int cyc, hi, first;
    run_period(change_at, nd, cyc, hi, first);
    chk({"R1 R5 period length ", tag}, cyc, n_exp);
    chk({"R3 high half-cycles ", tag}, hi, n_exp);
    chk({"R7 clk_div at tick ", tag}, first, (n_exp % 2 == 0) ? 1 : 0);
  endtask

  initial begin
    int lat;
    int cur;
    void'($urandom(32'h1d2c3b4a));

    // R6: outputs are low while reset is held.
    repeat (2) begin @(posedge clk); #1ns; end
    chk("R6 reset tick", int'(tick_o), 0);
    chk("R6 reset clk_div", int'(clk_div_o), 0);

    // R1 R4 R6: every legal value plus the out-of-range ends.
    for (int d = 0; d <= 18; d++) begin
      logic [4:0] dv;
      dv = (d == 18) ? 5'd31 : 5'(d);
      do_reset(dv, lat);
      chk($sformatf("R4 R6 first tick latency div=%0d", d), lat, ref_clamp(int'(dv)));
      check_period(ref_clamp(int'(dv)), 0, 5'd0, $sformatf("div=%0d", int'(dv)));
      check_period(ref_clamp(int'(dv)), 0, 5'd0, $sformatf("div=%0d", int'(dv)));
    end

    // R5: changes in the last cycle of a period, odd/even crossings.
    do_reset(5'd3, lat);
    check_period(3, 2, 5'd16, "R5 3 to 16 last cycle");
    check_period(16, 15, 5'd2, "R5 16 to 2 last cycle");
    check_period(2, 1, 5'd7, "R5 2 to 7");
    check_period(7, 3, 5'd1, "R5 7 to clamp 2 mid");
    check_period(2, 1, 5'd20, "R5 2 to clamp 16");
    check_period(16, 0, 5'd0, "R5 settled 16");

    // Random divisor changes at random offsets, occasional reset.
    cur = 16;
    for (int it = 0; it < 400; it++) begin
      logic [4:0] nd;
      int ca;
      nd = 5'($urandom_range(0, 31));
      if (it % 97 == 96) begin
        do_reset(nd, lat);
        chk("R6 latency after mid-run reset", lat, ref_clamp(int'(nd)));
        cur = ref_clamp(int'(nd));
      end else begin
        ca = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, cur - 1);
        check_period(cur, ca, nd, "random");
        if (ca != 0) cur = ref_clamp(int'(nd));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #750us;
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule